// File: doc/BRIEF.md
# Edge/Level Interrupt Service and EOI Unit

This unit sits between the raw interrupt request lines of a routing controller and the message path toward the processors. Each of `N` pins is either edge- or level-triggered, as set by an external redirection table. The table supplies, for each pin, the vector, destination, destination mode, delivery mode, trigger mode and mask. The unit keeps the per-pin request state and chooses which pin to serve next. It presents one delivery message at a time on a valid/ready handshake. When a request cannot produce a new delivery, it pulses a per-pin coalesced flag.

Level-triggered pins carry a remote-pending latch. An accepted delivery sets the latch, and it stays set until an end-of-interrupt (EOI) for the pin's vector arrives. If the line is still asserted when that EOI comes in, the pin is served again. A per-pin counter watches for an interrupt storm. When a run of EOIs has kept redelivering the same pin too many times, the next redelivery is held back for a fixed number of cycles. Redelivery resumes when a shared timer expires.

Top module: `irq_svc_unit`

## Requirements
- R1: A pin whose mask bit is 1 is never delivered. Its request is kept and is delivered once the mask bit returns to 0.
- R2: On an edge pin (`cfg_level_i` bit = 0), a 0→1 transition of the line makes `dlv_valid_o` rise two clock edges later. The message carries that pin's index, vector, destination, destination mode and delivery mode, and `dlv_level_o` = 0.
- R3: On an edge pin, a new rising edge that arrives while the previous edge is still undelivered gives a one-cycle pulse on that pin's `coal_o` bit. Both edges together produce only one delivery.
- R4: On a level pin (`cfg_level_i` bit = 1), an asserted line is delivered once, and acceptance sets remote-pending. No further delivery occurs while remote-pending is set. A new rising edge during that time pulses `coal_o`.
- R5: An EOI with `eoi_level_i`=1, `eoi_directed_i`=0 and `eoi_vector_i` equal to a level pin's vector clears that pin's remote-pending. If the pin is unmasked and its line is high, it is delivered again. An EOI with a different vector has no effect.
- R6: An EOI with `eoi_level_i`=0, or with `eoi_directed_i`=1, leaves remote-pending set, so no redelivery follows.
- R7: The `STORM_LIMIT`-th successive EOI that finds the pin unmasked with its line high resets the pin's counter. Instead of an immediate redelivery, the pin is deferred. When the shared timer expires `DEFER_CYC` cycles later, every deferred level pin with its line high and remote-pending clear is delivered.
- R8: A clearing EOI that finds the line low or the pin masked resets the pin's storm counter to zero.
- R9: Switching a pin to level mode while its line is high and remote-pending is clear delivers it without any other event.
- R10: Among pins pending at the same time, the lowest index is delivered first. With `dlv_ready_i` held high, one delivery is accepted per cycle.
- R11: While `dlv_valid_o`=1 and `dlv_ready_i`=0, the message stays valid and its pin and fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_line_i | input | N | Raw request line per pin |
| cfg_level_i | input | N | Trigger mode per pin, 1 = level |
| cfg_mask_i | input | N | Mask per pin, 1 = masked |
| cfg_vector_i | input | N*VW | Vector per pin, pin i at [i*VW +: VW] |
| cfg_dest_i | input | N*DW | Destination per pin |
| cfg_dest_logical_i | input | N | Destination mode per pin |
| cfg_dmode_i | input | N*3 | Delivery mode per pin |
| eoi_valid_i | input | 1 | EOI broadcast strobe |
| eoi_vector_i | input | VW | EOI vector |
| eoi_level_i | input | 1 | EOI is level-type |
| eoi_directed_i | input | 1 | Receiver uses directed-EOI mode |
| dlv_valid_o | output | 1 | Delivery message valid |
| dlv_ready_i | input | 1 | Delivery message accepted |
| dlv_pin_o | output | PW | Source pin index |
| dlv_vector_o | output | VW | Vector |
| dlv_dest_o | output | DW | Destination |
| dlv_dest_logical_o | output | 1 | Destination mode |
| dlv_dmode_o | output | 3 | Delivery mode |
| dlv_level_o | output | 1 | Trigger mode of the message |
| coal_o | output | N | Per-pin coalesced pulse |

## Verification
A rising line appears as `dlv_valid_o` two edges later: one edge registers the line and one loads the message. A clearing EOI also redelivers two edges after its strobe. A change in configuration is picked up at the next edge, and `coal_o` pulses in the cycle after the edge that saw the line rise. With a storm, redelivery waits about `DEFER_CYC`+2 cycles. The bench drives inputs one time unit after a rising edge and counts accepted handshakes at the falling edge. Each check either samples a fixed number of edges after its stimulus, as derived above, or waits a window large enough to cover that latency and compares the delivery count. For the deferred case, the check first confirms that nothing arrives during a window shorter than the delay.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  localparam int unsigned DMODE_W = 3;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl #(
  parameter int unsigned VW          = 8,
  parameter int unsigned STORM_LIMIT = 10000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic          level_i,
  input  logic          mask_i,
  input  logic [VW-1:0] vector_i,
  input  logic          eoi_valid_i,
  input  logic [VW-1:0] eoi_vector_i,
  input  logic          eoi_level_i,
  input  logic          eoi_directed_i,
  input  logic          acc_i,
  input  logic          defer_clr_i,
  output logic          req_o,
  output logic          coal_o,
  output logic          defer_set_o
);
  import irq_svc_pkg::*;
  localparam int unsigned CW = $clog2(STORM_LIMIT + 1);

  logic          line_q, pend_q, rirr_q, defer_q, coal_q;
  logic [CW-1:0] cnt_q;
  logic          rise, is_lvl, eoi_hit, storm_step, storm_trip;

  assign is_lvl     = (trig_e'(level_i) == TRIG_LEVEL);
  assign rise       = line_i & ~line_q;
  assign eoi_hit    = eoi_valid_i & eoi_level_i & ~eoi_directed_i & is_lvl
                      & (eoi_vector_i == vector_i);
  assign storm_step = eoi_hit & ~mask_i & line_q;
  assign storm_trip = storm_step & (cnt_q == CW'(STORM_LIMIT - 1));

  assign req_o       = is_lvl ? (line_q & ~rirr_q & ~mask_i & ~defer_q)
                              : (pend_q & ~mask_i);
  assign coal_o      = coal_q;
  assign defer_set_o = storm_trip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b0;
      pend_q  <= 1'b0;
      rirr_q  <= 1'b0;
      defer_q <= 1'b0;
      coal_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      line_q <= line_i;
      coal_q <= rise & (is_lvl ? rirr_q : (pend_q & ~acc_i));
      // edge capture; an accept in the same cycle consumes the old edge
      if (!is_lvl && rise)   pend_q <= 1'b1;
      else if (acc_i)        pend_q <= 1'b0;
      if (acc_i && is_lvl)   rirr_q <= 1'b1;
      else if (eoi_hit)      rirr_q <= 1'b0;
      if (eoi_hit) begin
        if (storm_trip)      cnt_q <= '0;
        else if (storm_step) cnt_q <= cnt_q + 1'b1;
        else                 cnt_q <= '0;
      end
      if (storm_trip)        defer_q <= 1'b1;
      else if (defer_clr_i)  defer_q <= 1'b0;
    end
  end

  // R4
  lvl_accept_sets_rirr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && level_i |=> rirr_q);
  // R6
  rirr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rirr_q && !(eoi_valid_i && eoi_level_i && !eoi_directed_i) |=> rirr_q);
  // R7
  storm_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_set_o |=> (cnt_q == '0) && defer_q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N  = 24,
  parameter int unsigned PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [PW-1:0] pin_o,
  output logic          load_o,
  output logic [PW-1:0] nxt_o,
  output logic [N-1:0]  acc_o
);
  logic          valid_q, acc, can_load;
  logic [PW-1:0] pin_q, nxt;
  logic [N-1:0]  cand, excl;

  assign acc      = valid_q & ready_i;
  assign can_load = ~valid_q | acc;

  generate
    for (genvar i = 0; i < N; i++) begin : g_acc
      assign excl[i]  = acc & (pin_q == PW'(i));
      assign acc_o[i] = excl[i];
    end
  endgenerate

  assign cand = req_i & ~excl;

  always_comb begin
    nxt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) nxt = PW'(i);
    end
  end

  assign load_o  = can_load & (|cand);
  assign nxt_o   = nxt;
  assign valid_o = valid_q;
  assign pin_o   = pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pin_q   <= '0;
    end else if (can_load) begin
      valid_q <= |cand;
      if (|cand) pin_q <= nxt;
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i |=> valid_q && $stable(pin_q));
endmodule

// File: rtl/irq_defer_timer.sv
module irq_defer_timer #(
  parameter int unsigned DEFER_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(DEFER_CYC + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign expire_o = run_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && (!run_q || expire_o)) begin
      run_q <= 1'b1;
      cnt_q <= CW'(DEFER_CYC - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  defer_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !run_q |=> run_q && !expire_o);
endmodule

// File: rtl/irq_svc_unit.sv
module irq_svc_unit
  import irq_svc_pkg::*;
#(
  parameter int unsigned N           = 24,
  parameter int unsigned VW          = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned STORM_LIMIT = 10000,
  parameter int unsigned DEFER_CYC   = 1000000,
  localparam int unsigned PW         = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         irq_line_i,
  input  logic [N-1:0]         cfg_level_i,
  input  logic [N-1:0]         cfg_mask_i,
  input  logic [N*VW-1:0]      cfg_vector_i,
  input  logic [N*DW-1:0]      cfg_dest_i,
  input  logic [N-1:0]         cfg_dest_logical_i,
  input  logic [N*DMODE_W-1:0] cfg_dmode_i,
  input  logic                 eoi_valid_i,
  input  logic [VW-1:0]        eoi_vector_i,
  input  logic                 eoi_level_i,
  input  logic                 eoi_directed_i,
  output logic                 dlv_valid_o,
  input  logic                 dlv_ready_i,
  output logic [PW-1:0]        dlv_pin_o,
  output logic [VW-1:0]        dlv_vector_o,
  output logic [DW-1:0]        dlv_dest_o,
  output logic                 dlv_dest_logical_o,
  output logic [DMODE_W-1:0]   dlv_dmode_o,
  output logic                 dlv_level_o,
  output logic [N-1:0]         coal_o
);
  logic [N-1:0]  req, acc, defer_set;
  logic          expire, load;
  logic [PW-1:0] nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      irq_pin_ctl #(.VW(VW), .STORM_LIMIT(STORM_LIMIT)) u_pin (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .line_i         (irq_line_i[i]),
        .level_i        (cfg_level_i[i]),
        .mask_i         (cfg_mask_i[i]),
        .vector_i       (cfg_vector_i[i*VW +: VW]),
        .eoi_valid_i    (eoi_valid_i),
        .eoi_vector_i   (eoi_vector_i),
        .eoi_level_i    (eoi_level_i),
        .eoi_directed_i (eoi_directed_i),
        .acc_i          (acc[i]),
        .defer_clr_i    (expire),
        .req_o          (req[i]),
        .coal_o         (coal_o[i]),
        .defer_set_o    (defer_set[i])
      );
    end
  endgenerate

  irq_pick #(.N(N), .PW(PW)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .ready_i (dlv_ready_i),
    .valid_o (dlv_valid_o),
    .pin_o   (dlv_pin_o),
    .load_o  (load),
    .nxt_o   (nxt),
    .acc_o   (acc)
  );

  irq_defer_timer #(.DEFER_CYC(DEFER_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (|defer_set),
    .expire_o (expire)
  );

  // message payload captured with the pick
  trig_e lvl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_vector_o       <= '0;
      dlv_dest_o         <= '0;
      dlv_dest_logical_o <= 1'b0;
      dlv_dmode_o        <= '0;
      lvl_q              <= TRIG_EDGE;
    end else if (load) begin
      dlv_vector_o       <= cfg_vector_i[nxt*VW +: VW];
      dlv_dest_o         <= cfg_dest_i[nxt*DW +: DW];
      dlv_dest_logical_o <= cfg_dest_logical_i[nxt];
      dlv_dmode_o        <= cfg_dmode_i[nxt*DMODE_W +: DMODE_W];
      lvl_q              <= trig_e'(cfg_level_i[nxt]);
    end
  end
  assign dlv_level_o = (lvl_q == TRIG_LEVEL);

  // R1
  no_masked_dlv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o && !$past(dlv_valid_o && !dlv_ready_i)
    |-> ((($past(cfg_mask_i) >> dlv_pin_o) & N'(1)) == '0));
endmodule

// File: tb/sim_irq_svc_unit.sv
module sim_irq_svc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, VW = 8, DW = 4, LIM = 3, DEF = 16, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] line = '0, lvl = '0, msk = '1, dlog = '0;
  logic [N*VW-1:0] vec = '0;
  logic [N*DW-1:0] dst = '0;
  logic [N*3-1:0]  dmd = '0;
  logic eoi_v = 1'b0, eoi_l = 1'b0, eoi_d = 1'b0, rdy = 1'b1;
  logic [VW-1:0] eoi_vec = '0;
  logic dv, dlog_o, dlvl;
  logic [PW-1:0] dpin;
  logic [VW-1:0] dvec;
  logic [DW-1:0] ddst;
  logic [2:0] ddm;
  logic [N-1:0] coal;

  int n_chk = 0, n_fail = 0, dl_cnt = 0, cyc = 0;
  int last_pin = 0, last_vec = 0, last_lvl = 0;
  int log_pin [32];
  int log_cyc [32];
  int coal_cnt [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_svc_unit #(.N(N), .VW(VW), .DW(DW), .STORM_LIMIT(LIM), .DEFER_CYC(DEF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_line_i(line), .cfg_level_i(lvl),
    .cfg_mask_i(msk), .cfg_vector_i(vec), .cfg_dest_i(dst),
    .cfg_dest_logical_i(dlog), .cfg_dmode_i(dmd), .eoi_valid_i(eoi_v),
    .eoi_vector_i(eoi_vec), .eoi_level_i(eoi_l), .eoi_directed_i(eoi_d),
    .dlv_valid_o(dv), .dlv_ready_i(rdy), .dlv_pin_o(dpin), .dlv_vector_o(dvec),
    .dlv_dest_o(ddst), .dlv_dest_logical_o(dlog_o), .dlv_dmode_o(ddm),
    .dlv_level_o(dlvl), .coal_o(coal));

  initial for (int i = 0; i < N; i++) coal_cnt[i] = 0;

  // handshake is stable between drive (posedge+1) and the next posedge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < N; i++) if (coal[i]) coal_cnt[i]++;
      if (dv && rdy) begin
        if (dl_cnt < 32) begin
          log_pin[dl_cnt] = int'(dpin);
          log_cyc[dl_cnt] = cyc;
        end
        dl_cnt++;
        last_pin = int'(dpin);
        last_vec = int'(dvec);
        last_lvl = int'(dlvl);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic set_pin(int p, bit level, bit mask, int v, int d);
    lvl[p] = level;
    msk[p] = mask;
    vec[p*VW +: VW] = VW'(v);
    dst[p*DW +: DW] = DW'(d);
    dmd[p*3 +: 3] = 3'(p + 1);
  endtask

  task automatic send_eoi(int v, bit level, bit directed);
    eoi_vec = VW'(v); eoi_l = level; eoi_d = directed; eoi_v = 1'b1;
    tick(1);
    eoi_v = 1'b0;
  endtask

  task automatic t_reset();
    chk(dv == 1'b0, "reset valid", int'(dv), 0);
    chk(coal == '0, "reset coal", int'(coal), 0);
  endtask

  task automatic t_edge();  // R2
    int b = dl_cnt;
    set_pin(0, 0, 0, 'h31, 5);
    line[0] = 1'b1;
    tick(1);
    chk(dv == 1'b0, "R2 not yet valid", int'(dv), 0);
    tick(1);
    chk(dv && dpin == 0 && dvec == 8'h31 && ddst == 4'd5 && ddm == 3'd1 && !dlvl,
        "R2 message", int'(dvec), 'h31);
    tick(1);
    chk(dl_cnt == b + 1 && dv == 1'b0, "R2 single delivery", dl_cnt - b, 1);
    line[0] = 1'b0;
    tick(2);
  endtask

  task automatic t_mask();  // R1
    int b = dl_cnt;
    set_pin(1, 0, 1, 'h32, 6);
    line[1] = 1'b1;
    tick(6);
    chk(dl_cnt == b && !dv, "R1 masked no delivery", dl_cnt - b, 0);
    msk[1] = 1'b0;
    tick(3);
    chk(dl_cnt == b + 1 && last_pin == 1, "R1 kept after unmask", dl_cnt - b, 1);
    line[1] = 1'b0;
    tick(2);
  endtask

  task automatic t_coal();  // R3
    int b = dl_cnt;
    int c = coal_cnt[0];
    rdy = 1'b0;
    line[0] = 1'b1; tick(1);
    line[0] = 1'b0; tick(1);
    line[0] = 1'b1; tick(1);
    line[0] = 1'b0; tick(2);
    chk(coal_cnt[0] == c + 1, "R3 coalesced pulse", coal_cnt[0] - c, 1);
    chk(dv == 1'b1, "R3 held valid", int'(dv), 1);
    rdy = 1'b1;
    tick(4);
    chk(dl_cnt == b + 1, "R3 one delivery", dl_cnt - b, 1);
  endtask

  task automatic t_hold();  // R11
    int p0, v0;
    rdy = 1'b0;
    line[1] = 1'b1;
    tick(3);
    p0 = int'(dpin); v0 = int'(dvec);
    tick(4);
    chk(dv && int'(dpin) == p0 && int'(dvec) == v0 && v0 == 'h32, "R11 held stable",
        int'(dvec), 'h32);
    rdy = 1'b1;
    tick(2);
    line[1] = 1'b0;
    tick(2);
  endtask

  task automatic t_order();  // R10
    int b = dl_cnt;
    rdy = 1'b0;
    line[1] = 1'b1; line[0] = 1'b1;
    tick(3);
    rdy = 1'b1;
    tick(3);
    chk(dl_cnt == b + 2, "R10 two deliveries", dl_cnt - b, 2);
    chk(log_pin[b] == 0 && log_pin[b+1] == 1, "R10 lowest first", log_pin[b], 0);
    chk(log_cyc[b+1] - log_cyc[b] == 1, "R10 one per cycle", log_cyc[b+1] - log_cyc[b], 1);
    line[0] = 1'b0; line[1] = 1'b0;
    tick(2);
  endtask

  task automatic t_level();  // R4
    int b = dl_cnt;
    int c = coal_cnt[2];
    set_pin(2, 1, 0, 'h42, 7);
    line[2] = 1'b1;
    tick(4);
    chk(dl_cnt == b + 1 && last_pin == 2 && last_lvl == 1, "R4 level delivered", dl_cnt - b, 1);
    tick(6);
    chk(dl_cnt == b + 1, "R4 blocked by remote-pending", dl_cnt - b, 1);
    line[2] = 1'b0; tick(1);
    line[2] = 1'b1; tick(4);
    chk(coal_cnt[2] == c + 1 && dl_cnt == b + 1, "R4 coalesced level", coal_cnt[2] - c, 1);
  endtask

  task automatic t_eoi();  // R5
    int b = dl_cnt;
    send_eoi('h55, 1, 0); tick(5);
    chk(dl_cnt == b, "R5 other vector ignored", dl_cnt - b, 0);
    send_eoi('h42, 1, 0); tick(4);
    chk(dl_cnt == b + 1 && last_pin == 2, "R5 redelivery", dl_cnt - b, 1);
    line[2] = 1'b0; tick(1);
    send_eoi('h42, 1, 0); tick(5);
    chk(dl_cnt == b + 1, "R5 line low no redelivery", dl_cnt - b, 1);
    line[2] = 1'b1; tick(4);
    chk(dl_cnt == b + 2, "R5 line reasserted", dl_cnt - b, 2);
  endtask

  task automatic t_noclr();  // R6
    int b = dl_cnt;
    send_eoi('h42, 1, 1); tick(5);
    chk(dl_cnt == b, "R6 directed EOI keeps pending", dl_cnt - b, 0);
    send_eoi('h42, 0, 0); tick(5);
    chk(dl_cnt == b, "R6 edge EOI keeps pending", dl_cnt - b, 0);
    send_eoi('h42, 1, 0); tick(4);
    chk(dl_cnt == b + 1, "R6 normal EOI clears", dl_cnt - b, 1);
  endtask

  task automatic t_storm();  // R8 then R7
    int b;
    line[2] = 1'b0; tick(1);
    send_eoi('h42, 1, 0); tick(2);
    line[2] = 1'b1; tick(4);
    b = dl_cnt;
    send_eoi('h42, 1, 0); tick(4);
    send_eoi('h42, 1, 0); tick(4);
    chk(dl_cnt == b + 2, "R8 counter cleared by low line", dl_cnt - b, 2);
    send_eoi('h42, 1, 0); tick(12);
    chk(dl_cnt == b + 2, "R7 redelivery deferred", dl_cnt - b, 2);
    tick(10);
    chk(dl_cnt == b + 3 && last_pin == 2, "R7 delivered after delay", dl_cnt - b, 3);
    line[2] = 1'b0;
    tick(2);
  endtask

  task automatic t_relevel();  // R9
    int b = dl_cnt;
    set_pin(3, 0, 0, 'h63, 9);
    line[3] = 1'b1;
    tick(4);
    chk(dl_cnt == b + 1 && last_lvl == 0, "R9 edge delivery first", dl_cnt - b, 1);
    tick(3);
    chk(dl_cnt == b + 1, "R9 no repeat as edge", dl_cnt - b, 1);
    lvl[3] = 1'b1;
    tick(3);
    chk(dl_cnt == b + 2 && last_pin == 3 && last_lvl == 1, "R9 service on mode change",
        dl_cnt - b, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_edge();
    t_mask();
    t_coal();
    t_hold();
    t_order();
    t_level();
    t_eoi();
    t_noclr();
    t_storm();
    t_relevel();
    tick(3);
    report();
    $finish;
  end
endmodule